// File: doc/BRIEF.md
# Packet Memory Host Access Port

This block gives a host processor 16-bit word access to a byte-addressed packet memory of 16 KiB. The memory holds two regions. Bytes 0 to 3071 form the transmit region, and bytes 3072 to 16383 form the receive region. The host fills the transmit region through a write pointer and drains the receive region through a read pointer. The block keeps both pointers.

All access goes through two host locations, selected by `hostSel`. A write to the address location latches a register index. Later data-location reads and writes act on that latched index. Each pointer can be loaded and read back one byte at a time. Four command indices move one word per access:
- an advancing word write and a non-advancing word write;
- an advancing word read and a non-advancing word read.

A wrap bit in the mode register decides what happens when a pointer reaches the end of its region. With wrap on, the pointer goes round in a circle inside the region. With wrap off, it stops short of the end.

The receive write pointer is an input from the frame receive logic, which lies outside this block. The non-advancing read compares against it so that the host can tell when the receive buffer is empty.

Read data is registered. It appears on `rdData` in the cycle after the read strobe and holds until the next read.

Top module: `pktmem_host_port`

## Requirements
- R1: A write with `hostSel`=0 latches `wrData[7:0]` as the register index. A read with `hostSel`=0 returns that index in bits 7:0. Data-location accesses never change the index.
- R2: After `rstN` low or a one-cycle `softRst` pulse, the write pointer is 0x0000, the read pointer is 0x0C00 (3072), and the mode register is 0x00.
- R3: Index 0x01 and 0x02 hold the write pointer's low and high bytes. Index 0x03 and 0x04 hold the read pointer's low and high bytes. Each byte is written and read alone, and the other byte is kept.
- R4: A word write at index 0x10 or 0x11 stores `wrData[7:0]` at byte address P and `wrData[15:8]` at P+1, where P is the write pointer. Addresses use the pointer's low 14 bits, so P+1 past 16383 lands on byte 0.
- R5: A data write at index 0x10 adds 2 to the write pointer. A data write at index 0x11 leaves the write pointer unchanged.
- R6: The wrap bit is mode bit 7. With wrap on, an advancing write whose sum P+2 is at least 3072 sets the pointer to P+2-3072. With wrap off, the pointer advances only if P+2 < 3072; otherwise it holds.
- R7: A data read at index 0x12 returns the byte at the read pointer Q in bits 7:0 and the byte at Q+1 in bits 15:8, including odd Q. It then adds 2 to the read pointer.
- R8: With wrap on, an advancing read whose sum Q+2 is at least 16384 sets the pointer to Q+2-13312. With wrap off, the read pointer advances only if Q+2 < 16384; otherwise it holds.
- R9: A data read at index 0x13 returns the same word as index 0x12 without moving the read pointer. It returns 0x0000 when the read pointer equals `rxWrPtr`.
- R10: A mode write at index 0x00 that turns bit 7 from 0 to 1 sets the read pointer's high byte to 0x0C and keeps its low byte. A mode write while bit 7 is already 1 leaves the read pointer alone.
- R11: Data reads at an unmapped index (for example 0x40) return 0x0000. Data writes there change neither pointer nor the mode register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| softRst | input | 1 | One-cycle pulse; returns pointers and mode to their reset values |
| hostSel | input | 1 | 0 selects the address location, 1 the data location |
| hostWr | input | 1 | Host write strobe, one cycle per access |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| wrData | input | 16 | Host write data |
| rxWrPtr | input | 16 | Receive write pointer from the frame receive logic |
| rdData | output | 16 | Registered host read data, valid the cycle after `hostRd` |

## Verification
The properties assume the following about the inputs:
- `hostWr` and `hostRd` are never high together.
- `softRst` does not coincide with a host access.
- `rxWrPtr` changes only between accesses.

The stimulus drives every access as a single strobe cycle from a task, so the two strobes are never raised together. It pulses `softRst` only while both strobes are low. It changes `rxWrPtr` only while idle.

Memory words are read only at addresses that the stimulus wrote earlier. No check therefore depends on the unreset contents of the memory array.

// File: rtl/pktmem_pkg.sv
`timescale 1ns/1ps
package pktmem_pkg;

  localparam int PTR_W = 16;

  localparam logic [7:0] IDX_MODE    = 8'h00;
  localparam logic [7:0] IDX_WP_LO   = 8'h01;
  localparam logic [7:0] IDX_WP_HI   = 8'h02;
  localparam logic [7:0] IDX_RP_LO   = 8'h03;
  localparam logic [7:0] IDX_RP_HI   = 8'h04;
  localparam logic [7:0] IDX_WR_ADV  = 8'h10;
  localparam logic [7:0] IDX_WR_PEEK = 8'h11;
  localparam logic [7:0] IDX_RD_ADV  = 8'h12;
  localparam logic [7:0] IDX_RD_PEEK = 8'h13;

  typedef enum logic [3:0] {
    SRC_ZERO, SRC_INDEX, SRC_MODE, SRC_WPLO, SRC_WPHI,
    SRC_RPLO, SRC_RPHI, SRC_WORD, SRC_PEEK
  } rdsrc_e;

  typedef struct packed {
    logic   modeWr;
    logic   wpLoWr;
    logic   wpHiWr;
    logic   rpLoWr;
    logic   rpHiWr;
    logic   wpStep;
    logic   rpStep;
    logic   capture;
    rdsrc_e src;
  } strobe_t;

endpackage

// File: rtl/pktmem_ctrl.sv
`timescale 1ns/1ps
module pktmem_ctrl
  import pktmem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [7:0] wrByte,
  output logic [7:0] regIdx,
  output strobe_t    strb,
  output logic       memWr,
  output logic       memRd,
  output rdsrc_e     srcQ
);

  // Latched register index; only the address location changes it.
  always_ff @(posedge clk) begin
    if (!rstN)                 regIdx <= 8'h00;
    else if (hostWr && !hostSel) regIdx <= wrByte;
  end

  // Decode of the latched index into one-cycle strobes.
  always_comb begin
    strb     = '0;
    strb.src = SRC_ZERO;
    memWr    = 1'b0;
    memRd    = 1'b0;
    if (hostWr && hostSel) begin
      case (regIdx)
        IDX_MODE:    strb.modeWr = 1'b1;
        IDX_WP_LO:   strb.wpLoWr = 1'b1;
        IDX_WP_HI:   strb.wpHiWr = 1'b1;
        IDX_RP_LO:   strb.rpLoWr = 1'b1;
        IDX_RP_HI:   strb.rpHiWr = 1'b1;
        IDX_WR_ADV: begin
          memWr       = 1'b1;
          strb.wpStep = 1'b1;
        end
        IDX_WR_PEEK: memWr = 1'b1;
        default: ;
      endcase
    end else if (hostRd) begin
      strb.capture = 1'b1;
      if (!hostSel) begin
        strb.src = SRC_INDEX;
      end else begin
        case (regIdx)
          IDX_MODE:  strb.src = SRC_MODE;
          IDX_WP_LO: strb.src = SRC_WPLO;
          IDX_WP_HI: strb.src = SRC_WPHI;
          IDX_RP_LO: strb.src = SRC_RPLO;
          IDX_RP_HI: strb.src = SRC_RPHI;
          IDX_RD_ADV: begin
            memRd       = 1'b1;
            strb.rpStep = 1'b1;
            strb.src    = SRC_WORD;
          end
          IDX_RD_PEEK: begin
            memRd    = 1'b1;
            strb.src = SRC_PEEK;
          end
          default: strb.src = SRC_ZERO;
        endcase
      end
    end
  end

  // Source of the read data held for the cycles after a read.
  always_ff @(posedge clk) begin
    if (!rstN)             srcQ <= SRC_ZERO;
    else if (strb.capture) srcQ <= strb.src;
  end

endmodule

// File: rtl/pktmem_ptr_regs.sv
`timescale 1ns/1ps
module pktmem_ptr_regs
  import pktmem_pkg::*;
#(
  parameter int TX_BYTES = 3072,
  parameter int RX_BYTES = 13312
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  strobe_t          strb,
  input  logic [7:0]       wrByte,
  input  logic [7:0]       regIdx,
  input  logic [PTR_W-1:0] rxWrPtr,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [7:0]       modeReg,
  output logic [7:0]       regByte,
  output logic             peekEmpty
);

  localparam int MEM_BYTES = TX_BYTES + RX_BYTES;

  // Wide limits for the comparisons, pointer-width constants for the arithmetic.
  localparam logic [PTR_W:0]   TX_LIM  = (PTR_W+1)'(TX_BYTES);
  localparam logic [PTR_W:0]   MEM_LIM = (PTR_W+1)'(MEM_BYTES);
  localparam logic [PTR_W:0]   STEP_W  = (PTR_W+1)'(2);
  localparam logic [PTR_W-1:0] STEP    = PTR_W'(2);
  localparam logic [PTR_W-1:0] TX_SPAN = PTR_W'(TX_BYTES);
  localparam logic [PTR_W-1:0] RX_SPAN = PTR_W'(RX_BYTES);
  localparam logic [PTR_W-1:0] RX_BASE = PTR_W'(TX_BYTES);
  localparam logic [7:0]       RX_HI   = 8'(TX_BYTES >> 8);

  logic             wrapOn;
  logic [PTR_W:0]   wpSum, rpSum;
  logic             wpPast, rpPast;
  logic [PTR_W-1:0] wpNext, rpNext;

  assign wrapOn = modeReg[7];
  assign wpSum  = {1'b0, wrPtr} + STEP_W;
  assign rpSum  = {1'b0, rdPtr} + STEP_W;
  assign wpPast = (wpSum >= TX_LIM);
  assign rpPast = (rpSum >= MEM_LIM);

  // Next pointer values: circular wrap inside the region, or clip before its end.
  always_comb begin
    if (wrapOn) wpNext = wpPast ? (wrPtr + STEP - TX_SPAN) : (wrPtr + STEP);
    else        wpNext = wpPast ? wrPtr : (wrPtr + STEP);
    if (wrapOn) rpNext = rpPast ? (rdPtr + STEP - RX_SPAN) : (rdPtr + STEP);
    else        rpNext = rpPast ? rdPtr : (rdPtr + STEP);
  end

  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      wrPtr   <= '0;
      rdPtr   <= RX_BASE;
      modeReg <= 8'h00;
    end else begin
      if (strb.modeWr) begin
        modeReg <= wrByte;
        if (!wrapOn && wrByte[7]) rdPtr[15:8] <= RX_HI;
      end
      if (strb.wpLoWr) wrPtr[7:0]  <= wrByte;
      if (strb.wpHiWr) wrPtr[15:8] <= wrByte;
      if (strb.rpLoWr) rdPtr[7:0]  <= wrByte;
      if (strb.rpHiWr) rdPtr[15:8] <= wrByte;
      if (strb.wpStep) wrPtr <= wpNext;
      if (strb.rpStep) rdPtr <= rpNext;
    end
  end

  // Snapshot of the addressed byte register, taken at the read strobe.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regByte   <= 8'h00;
      peekEmpty <= 1'b0;
    end else if (strb.capture) begin
      peekEmpty <= (rdPtr == rxWrPtr);
      case (strb.src)
        SRC_INDEX: regByte <= regIdx;
        SRC_MODE:  regByte <= modeReg;
        SRC_WPLO:  regByte <= wrPtr[7:0];
        SRC_WPHI:  regByte <= wrPtr[15:8];
        SRC_RPLO:  regByte <= rdPtr[7:0];
        SRC_RPHI:  regByte <= rdPtr[15:8];
        default:   regByte <= 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/pktmem_banks.sv
`timescale 1ns/1ps
module pktmem_banks #(
  parameter int MEM_BYTES = 16384
) (
  input  logic                         clk,
  input  logic                         memWr,
  input  logic                         memRd,
  input  logic [$clog2(MEM_BYTES)-1:0] wrAddr,
  input  logic [$clog2(MEM_BYTES)-1:0] rdAddr,
  input  logic [15:0]                  wrWord,
  output logic [15:0]                  rdWord
);

  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int ROWS   = MEM_BYTES / 2;

  logic swapQ;

  always_ff @(posedge clk) begin
    if (memRd) swapQ <= rdAddr[0];
  end

  // Bank 0 holds even byte addresses and bank 1 odd ones. An odd pointer takes
  // its low byte from bank 1 and its high byte from the next row of bank 0.
  for (genvar g = 0; g < 2; g++) begin : gBank
    localparam bit ODD = (g == 1);
    logic [7:0]        mem [ROWS];
    logic [ADDR_W-1:0] wSum, rSum;
    logic [7:0]        wByte;
    logic [7:0]        rdByte;

    always_comb begin
      wSum  = wrAddr + ADDR_W'(1 - g);
      rSum  = rdAddr + ADDR_W'(1 - g);
      wByte = (wrAddr[0] ^ ODD) ? wrWord[15:8] : wrWord[7:0];
    end

    always_ff @(posedge clk) begin
      if (memWr) mem[wSum[ADDR_W-1:1]] <= wByte;
      if (memRd) rdByte <= mem[rSum[ADDR_W-1:1]];
    end
  end

  assign rdWord = swapQ ? {gBank[0].rdByte, gBank[1].rdByte}
                        : {gBank[1].rdByte, gBank[0].rdByte};

endmodule

// File: rtl/pktmem_host_port.sv
`timescale 1ns/1ps
module pktmem_host_port
  import pktmem_pkg::*;
#(
  parameter int TX_BYTES = 3072,
  parameter int RX_BYTES = 13312
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  logic        hostSel,
  input  logic        hostWr,
  input  logic        hostRd,
  input  logic [15:0] wrData,
  input  logic [15:0] rxWrPtr,
  output logic [15:0] rdData
);

  localparam int MEM_BYTES = TX_BYTES + RX_BYTES;
  localparam int ADDR_W    = $clog2(MEM_BYTES);

  logic [7:0]       regIdx;
  strobe_t          strb;
  logic             memWr, memRd;
  rdsrc_e           srcQ;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [7:0]       modeReg, regByte;
  logic             peekEmpty, wrapOn;
  logic [15:0]      memWord;

  assign wrapOn = modeReg[7];

  pktmem_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .hostSel(hostSel),
    .hostWr (hostWr),
    .hostRd (hostRd),
    .wrByte (wrData[7:0]),
    .regIdx (regIdx),
    .strb   (strb),
    .memWr  (memWr),
    .memRd  (memRd),
    .srcQ   (srcQ)
  );

  pktmem_ptr_regs #(.TX_BYTES(TX_BYTES), .RX_BYTES(RX_BYTES)) ptr_i (
    .clk      (clk),
    .rstN     (rstN),
    .softRst  (softRst),
    .strb     (strb),
    .wrByte   (wrData[7:0]),
    .regIdx   (regIdx),
    .rxWrPtr  (rxWrPtr),
    .wrPtr    (wrPtr),
    .rdPtr    (rdPtr),
    .modeReg  (modeReg),
    .regByte  (regByte),
    .peekEmpty(peekEmpty)
  );

  pktmem_banks #(.MEM_BYTES(MEM_BYTES)) mem_i (
    .clk   (clk),
    .memWr (memWr),
    .memRd (memRd),
    .wrAddr(wrPtr[ADDR_W-1:0]),
    .rdAddr(rdPtr[ADDR_W-1:0]),
    .wrWord(wrData),
    .rdWord(memWord)
  );

  always_comb begin
    case (srcQ)
      SRC_ZERO: rdData = 16'h0000;
      SRC_WORD: rdData = memWord;
      SRC_PEEK: rdData = peekEmpty ? 16'h0000 : memWord;
      default:  rdData = {8'h00, regByte};
    endcase
  end

endmodule

// File: rtl/pktmem_host_port_chk.sv
`timescale 1ns/1ps
module pktmem_host_port_chk
  import pktmem_pkg::*;
#(
  parameter int TX_BYTES = 3072
) (
  input logic        clk,
  input logic        rstN,
  input logic        softRst,
  input logic        hostSel,
  input logic        hostWr,
  input logic        hostRd,
  input logic [15:0] wrData,
  input logic [15:0] rxWrPtr,
  input logic [15:0] rdData,
  input logic [7:0]  regIdx,
  input logic [15:0] wrPtr,
  input logic [15:0] rdPtr,
  input logic        wrapOn
);

  localparam logic [7:0] RX_HI = 8'(TX_BYTES >> 8);

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWr && hostRd));

  AST_IDX_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    hostSel && (hostWr || hostRd) |=> $stable(regIdx)); // R1

  AST_SOFT_RESET_PTRS: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (wrPtr == 16'h0000) && (rdPtr == 16'(TX_BYTES))); // R2

  AST_WR_PEEK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    hostWr && hostSel && (regIdx == IDX_WR_PEEK) && !softRst |=> $stable(wrPtr)); // R5

  AST_WP_IN_REGION: assert property (@(posedge clk) disable iff (!rstN)
    wrapOn && hostWr && hostSel && (regIdx == IDX_WR_ADV) && !softRst
      && (int'(wrPtr) < TX_BYTES) |=> (int'(wrPtr) < TX_BYTES)); // R6

  AST_WP_CLIP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrapOn && hostWr && hostSel && (regIdx == IDX_WR_ADV) && !softRst
      && (int'(wrPtr) + 2 >= TX_BYTES) |=> $stable(wrPtr)); // R6

  AST_RD_PEEK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    hostRd && hostSel && (regIdx == IDX_RD_PEEK) && !softRst |=> $stable(rdPtr)); // R9

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    hostRd && hostSel && (regIdx == IDX_RD_PEEK) && (rdPtr == rxWrPtr)
      |=> (rdData == 16'h0000)); // R9

  AST_WRAP_ON_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    hostWr && hostSel && (regIdx == IDX_MODE) && wrData[7] && !wrapOn && !softRst
      |=> (rdPtr[15:8] == RX_HI) && (rdPtr[7:0] == $past(rdPtr[7:0]))); // R10

endmodule

bind pktmem_host_port pktmem_host_port_chk #(.TX_BYTES(TX_BYTES)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .softRst(softRst),
  .hostSel(hostSel),
  .hostWr (hostWr),
  .hostRd (hostRd),
  .wrData (wrData),
  .rxWrPtr(rxWrPtr),
  .rdData (rdData),
  .regIdx (regIdx),
  .wrPtr  (wrPtr),
  .rdPtr  (rdPtr),
  .wrapOn (wrapOn)
);

// File: tb/pktmem_host_port_tb_top.sv
`timescale 1ns/1ps
module pktmem_host_port_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic        hostSel = 1'b0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [15:0] wrData = 16'h0000;
  logic [15:0] rxWrPtr = 16'h3000;
  logic [15:0] rdData;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string curReq = "R2";

  always #4 clk = ~clk;

  pktmem_host_port dut_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .hostSel(hostSel),
    .hostWr(hostWr), .hostRd(hostRd), .wrData(wrData),
    .rxWrPtr(rxWrPtr), .rdData(rdData)
  );

  // Behavioural reference model, updated on every rising edge.
  int         mIdx, mMode, mWp, mRp;
  bit [7:0]   mMem [int];
  logic [15:0] mRd = 16'h0000;

  function automatic int memByte(int a);
    int k = a % 16384;
    return mMem.exists(k) ? int'(mMem[k]) : 0;
  endfunction

  function automatic int wordAt(int p);
    return memByte(p) | (memByte(p + 1) << 8);
  endfunction

  function automatic int nextWp(int p);
    if (mMode & 'h80) return (p + 2 >= 3072) ? p + 2 - 3072 : p + 2;
    return (p + 2 < 3072) ? p + 2 : p;
  endfunction

  function automatic int nextRp(int p);
    if (mMode & 'h80) return (p + 2 >= 16384) ? p + 2 - 13312 : p + 2;
    return (p + 2 < 16384) ? p + 2 : p;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mIdx = 0; mMode = 0; mWp = 0; mRp = 3072; mRd = 16'h0000;
    end else if (softRst) begin
      mWp = 0; mRp = 3072; mMode = 0;
    end else if (hostWr) begin
      if (!hostSel) mIdx = int'(wrData[7:0]);
      else case (mIdx)
        'h00: begin
          if (((mMode & 'h80) == 0) && wrData[7]) mRp = 'h0C00 | (mRp & 'hFF);
          mMode = int'(wrData[7:0]);
        end
        'h01: mWp = (mWp & 'hFF00) | int'(wrData[7:0]);
        'h02: mWp = (mWp & 'h00FF) | (int'(wrData[7:0]) << 8);
        'h03: mRp = (mRp & 'hFF00) | int'(wrData[7:0]);
        'h04: mRp = (mRp & 'h00FF) | (int'(wrData[7:0]) << 8);
        'h10, 'h11: begin
          mMem[mWp % 16384]       = wrData[7:0];
          mMem[(mWp + 1) % 16384] = wrData[15:8];
          if (mIdx == 'h10) mWp = nextWp(mWp) & 'hFFFF;
        end
        default: ;
      endcase
    end else if (hostRd) begin
      if (!hostSel) mRd = 16'(mIdx);
      else case (mIdx)
        'h00: mRd = 16'(mMode);
        'h01: mRd = 16'(mWp & 'hFF);
        'h02: mRd = 16'(mWp >> 8);
        'h03: mRd = 16'(mRp & 'hFF);
        'h04: mRd = 16'(mRp >> 8);
        'h12: begin mRd = 16'(wordAt(mRp)); mRp = nextRp(mRp) & 'hFFFF; end
        'h13: mRd = (mRp == int'(rxWrPtr)) ? 16'h0000 : 16'(wordAt(mRp));
        default: mRd = 16'h0000;
      endcase
    end
  end

  // Every-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (rdData !== mRd) begin
        fails++;
        $display("FAIL %s model compare: act=%h exp=%h at %0t", curReq, rdData, mRd, $time);
      end
    end
  end

  task automatic check(input logic [15:0] exp, input string req, input string what);
    checks++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, rdData, exp);
    end
  endtask

  task automatic access(input bit wr, input bit sel, input logic [15:0] d);
    hostWr = wr; hostRd = !wr; hostSel = sel; wrData = d;
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0;
  endtask

  task automatic setIdx(input logic [7:0] idx);
    access(1'b1, 1'b0, {8'h00, idx});
  endtask

  task automatic wrReg(input logic [7:0] idx, input logic [15:0] v);
    setIdx(idx);
    access(1'b1, 1'b1, v);
  endtask

  task automatic rdReg(input logic [7:0] idx, input logic [15:0] exp,
                       input string req, input string what);
    setIdx(idx);
    access(1'b0, 1'b1, 16'h0000);
    check(exp, req, what);
  endtask

  task automatic pulseSoft();
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 / R1: state after reset
    curReq = "R1";
    access(1'b0, 1'b0, 16'h0000);
    check(16'h0000, "R1", "index after reset");
    curReq = "R2";
    rdReg(8'h03, 16'h0000, "R2", "rd ptr low after reset");
    rdReg(8'h04, 16'h000C, "R2", "rd ptr high after reset");
    rdReg(8'h01, 16'h0000, "R2", "wr ptr low after reset");
    rdReg(8'h02, 16'h0000, "R2", "wr ptr high after reset");
    rdReg(8'h00, 16'h0000, "R2", "mode after reset");

    // R1: index latch and readback
    curReq = "R1";
    setIdx(8'h03);
    access(1'b0, 1'b0, 16'h0000);
    check(16'h0003, "R1", "latched index");

    // R3: byte-wise pointer load
    curReq = "R3";
    wrReg(8'h01, 16'h0010);
    wrReg(8'h02, 16'h0000);
    rdReg(8'h01, 16'h0010, "R3", "wr ptr low load");
    wrReg(8'h04, 16'h002A);
    rdReg(8'h03, 16'h0000, "R3", "rd ptr low kept");
    rdReg(8'h04, 16'h002A, "R3", "rd ptr high load");

    // R4 / R5: word writes, advancing and not
    curReq = "R5";
    setIdx(8'h10);
    access(1'b1, 1'b1, 16'hA1B2);
    access(1'b1, 1'b1, 16'hC3D4);
    rdReg(8'h01, 16'h0014, "R5", "wr ptr after two advancing writes");
    wrReg(8'h11, 16'h5566);
    rdReg(8'h01, 16'h0014, "R5", "wr ptr after non-advancing write");

    // R4 / R7: word reads, even and odd pointer
    curReq = "R7";
    wrReg(8'h03, 16'h0010);
    wrReg(8'h04, 16'h0000);
    setIdx(8'h12);
    access(1'b0, 1'b1, 16'h0000);
    check(16'hA1B2, "R4", "byte order of first word");
    access(1'b0, 1'b1, 16'h0000);
    check(16'hC3D4, "R7", "second advancing read");
    rdReg(8'h03, 16'h0014, "R7", "rd ptr after two reads");
    wrReg(8'h03, 16'h0011);
    setIdx(8'h12);
    access(1'b0, 1'b1, 16'h0000);
    check(16'hD4A1, "R7", "odd pointer read");

    // R9: non-advancing read and empty report
    curReq = "R9";
    wrReg(8'h03, 16'h0014);
    setIdx(8'h13);
    access(1'b0, 1'b1, 16'h0000);
    check(16'h5566, "R9", "peek read data");
    rdReg(8'h03, 16'h0014, "R9", "rd ptr after peek");
    rxWrPtr = 16'h0014;
    setIdx(8'h13);
    access(1'b0, 1'b1, 16'h0000);
    check(16'h0000, "R9", "peek when empty");
    rxWrPtr = 16'h3000;

    // R6 / R10: clip at the transmit end, then wrap
    curReq = "R6";
    wrReg(8'h01, 16'h00FE);
    wrReg(8'h02, 16'h000B);
    wrReg(8'h10, 16'h1234);
    rdReg(8'h01, 16'h00FE, "R6", "clip holds wr ptr low");
    rdReg(8'h02, 16'h000B, "R6", "clip holds wr ptr high");
    curReq = "R10";
    wrReg(8'h00, 16'h0080);
    rdReg(8'h04, 16'h000C, "R10", "rd ptr high on wrap enable");
    rdReg(8'h03, 16'h0014, "R10", "rd ptr low kept on wrap enable");
    curReq = "R6";
    wrReg(8'h10, 16'h9999);
    rdReg(8'h01, 16'h0000, "R6", "wr ptr wraps low");
    rdReg(8'h02, 16'h0000, "R6", "wr ptr wraps high");

    // R8: read wrap and clip at the memory end
    curReq = "R8";
    wrReg(8'h01, 16'h00FE);
    wrReg(8'h02, 16'h003F);
    wrReg(8'h11, 16'h7788);
    wrReg(8'h03, 16'h00FE);
    wrReg(8'h04, 16'h003F);
    setIdx(8'h12);
    access(1'b0, 1'b1, 16'h0000);
    check(16'h7788, "R8", "read at last word");
    rdReg(8'h03, 16'h0000, "R8", "wrapped rd ptr low");
    rdReg(8'h04, 16'h000C, "R8", "wrapped rd ptr high");
    wrReg(8'h00, 16'h0000);
    wrReg(8'h03, 16'h00FE);
    wrReg(8'h04, 16'h003F);
    setIdx(8'h12);
    access(1'b0, 1'b1, 16'h0000);
    check(16'h7788, "R8", "clip mode read data");
    rdReg(8'h03, 16'h00FE, "R8", "clip holds rd ptr low");
    rdReg(8'h04, 16'h003F, "R8", "clip holds rd ptr high");

    // R10: enable rewrites, repeat enable does not
    curReq = "R10";
    wrReg(8'h00, 16'h0080);
    rdReg(8'h04, 16'h000C, "R10", "rd ptr high from 0x3F");
    wrReg(8'h03, 16'h0033);
    wrReg(8'h04, 16'h0020);
    wrReg(8'h00, 16'h0081);
    rdReg(8'h04, 16'h0020, "R10", "no rewrite when already on");
    rdReg(8'h00, 16'h0081, "R10", "mode readback");

    // R11: unmapped index
    curReq = "R11";
    wrReg(8'h40, 16'hFFFF);
    rdReg(8'h40, 16'h0000, "R11", "unmapped read");
    rdReg(8'h04, 16'h0020, "R11", "rd ptr untouched");
    rdReg(8'h00, 16'h0081, "R11", "mode untouched");

    // R2: soft reset
    curReq = "R2";
    pulseSoft();
    rdReg(8'h01, 16'h0000, "R2", "wr ptr low after soft reset");
    rdReg(8'h04, 16'h000C, "R2", "rd ptr high after soft reset");
    rdReg(8'h03, 16'h0000, "R2", "rd ptr low after soft reset");
    rdReg(8'h00, 16'h0000, "R2", "mode after soft reset");

    // Mixed register and write traffic against the model
    curReq = "R3";
    for (int i = 0; i < 400; i++) begin
      int kind = $urandom_range(0, 9);
      logic [7:0] pick;
      case ($urandom_range(0, 7))
        0: pick = 8'h00; 1: pick = 8'h01; 2: pick = 8'h02; 3: pick = 8'h03;
        4: pick = 8'h04; 5: pick = 8'h10; 6: pick = 8'h11; default: pick = 8'h40;
      endcase
      if (kind < 3)       setIdx(pick);
      else if (kind < 6)  access(1'b1, 1'b1, 16'($urandom));
      else if (kind < 9) begin
        if (mIdx != 'h12 && mIdx != 'h13) access(1'b0, 1'b1, 16'h0000);
        else access(1'b0, 1'b0, 16'h0000);
      end else            pulseSoft();
    end
    rdReg(8'h01, 16'(mWp & 'hFF), "R3", "wr ptr low after traffic");
    rdReg(8'h04, 16'(mRp >> 8), "R3", "rd ptr high after traffic");

    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule